// File: doc/BRIEF.md
# Paged PHY Control and Status Register File

This block is the register file that sits between a serial-bus physical layer and the link logic that configures it. It is reached over a small synchronous bus: a 4-bit address, 8-bit write and read data, and separate write and read strobes. Its base registers hold four control bits, a one-shot request for a short arbitrated bus reset, four sticky status bits that are cleared by writing one to them, and the selector that steers a paged window.

The status bits are set by the hardware around the register file. Single-cycle pulses from the arbitration logic mark a loop or an arbitration timeout. A falling edge on the sampled cable-power-present input marks a power failure. The port event bit is set when a status line changes on a port whose interrupt enable is on, or when a port starts a resume while the watchdog bit is on. Addresses 8 to 15 form a window. A page field picks what the window shows, and a port field picks one port of the per-port page, where that port's live status and its interrupt enable can be read.

Top module: `phy_csr_file`

## Requirements
- R1: After reset, address 0 (control) reads 0x00, address 1 (status) reads 0x04 (power-fail set, all other bits clear), address 2 (select) reads 0x00, and the request, acceleration and multispeed outputs are low.
- R2: Writing address 0 with bit 3 set drives `short_reset_req` high for exactly the one cycle after the write. Bit 3 of address 0 always reads as zero.
- R3: In the status register at address 1 (bit 0 loop, bit 1 arbitration timeout, bit 2 power-fail, bit 3 port event), writing a one to a bit clears it and writing a zero leaves it unchanged.
- R4: If a hardware set event and a write-one-to-clear of the same status bit arrive in the same cycle, the bit ends up set.
- R5: A one-cycle pulse on `loop_pulse` sets status bit 0, and a one-cycle pulse on `arb_timeout_pulse` sets status bit 1.
- R6: Status bit 2 sets when the registered `cable_pwr_ok` goes from one to zero.
- R7: A change in connected, bias, disabled or fault on a port whose interrupt enable is one sets status bit 3. The same change on a port whose enable is zero leaves the bit clear.
- R8: A `port_resume` pulse on any port sets status bit 3 only while the watchdog bit (address 0, bit 0) is one.
- R9: Address 0 bit 1 (acceleration enable) and bit 2 (multispeed enable) are read/write and drive `accel_en` and `multi_en`.
- R10: Address 2 holds the page in bits 2:0 and the port in bits 7:4. On page 0, address 8 reads {4'b0, fault, disabled, bias, connected} of the selected port, and address 9 bit 0 is that port's read/write interrupt enable.
- R11: Reads of addresses 8 to 15 return zero when the page is not 0, when the port is at or above NUM_PORTS, or when the offset is unused. Writes in those cases change nothing. Addresses 3 to 7 also read zero.
- R12: `rdata` is loaded on the clock edge at which `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| loop_pulse | input | 1 | Loop detected pulse |
| arb_timeout_pulse | input | 1 | Arbitration timeout pulse |
| cable_pwr_ok | input | 1 | Cable power present |
| port_connected | input | NUM_PORTS | Per-port connected status |
| port_bias | input | NUM_PORTS | Per-port bias status |
| port_disabled | input | NUM_PORTS | Per-port disabled status |
| port_fault | input | NUM_PORTS | Per-port fault status |
| port_resume | input | NUM_PORTS | Per-port resume start pulse |
| short_reset_req | output | 1 | One-cycle short bus reset request |
| accel_en | output | 1 | Arbitration acceleration enable |
| multi_en | output | 1 | Multispeed concatenation enable |

## Verification
The window is tested by walking the port field across all three configured ports, each of which has a different status pattern, and then past the last port. A wrong shift or a wrong bound then shows up as another port's bits rather than zeros. Unimplemented pages and writes to an absent port's enable are read back, to catch decode that leaks writes. Each status bit is driven on its own by its event source, and the collision of a set event with a clear is tested separately from a plain clear. Status changes and resume pulses are applied with the interrupt enable or the watchdog off and then on, so that the gating is tested separately from the detection.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] A_SELECT = 4'd2;

  localparam logic [2:0] PAGE_PORT   = 3'd0;
  localparam logic [2:0] OFS_PSTAT   = 3'd0;
  localparam logic [2:0] OFS_INTEN   = 3'd1;

  localparam int C_WATCHDOG = 0;
  localparam int C_ACCEL    = 1;
  localparam int C_MULTI    = 2;
  localparam int C_SRST     = 3;

  localparam int S_LOOP  = 0;
  localparam int S_TMO   = 1;
  localparam int S_PWR   = 2;
  localparam int S_PEVT  = 3;
  localparam int N_STAT  = 4;
  localparam logic [N_STAT-1:0] STAT_RST = 4'b0100;

  typedef struct packed {
    logic fault;
    logic disabled;
    logic bias;
    logic connected;
  } port_stat_t;
endpackage

// File: rtl/csr_w1c_bit.sv
module csr_w1c_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/csr_port_monitor.sv
module csr_port_monitor #(
  parameter int NUM_PORTS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   connected_i,
  input  logic [NUM_PORTS-1:0]   bias_i,
  input  logic [NUM_PORTS-1:0]   disabled_i,
  input  logic [NUM_PORTS-1:0]   fault_i,
  input  logic [NUM_PORTS-1:0]   int_en_i,
  output logic [NUM_PORTS*4-1:0] stat_o,
  output logic                   change_o
);
  import phy_csr_pkg::*;

  logic [NUM_PORTS-1:0] hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_stat_t cur_q, prev_q;
    port_stat_t cur_d;

    always_comb begin
      cur_d.connected = connected_i[p];
      cur_d.bias      = bias_i[p];
      cur_d.disabled  = disabled_i[p];
      cur_d.fault     = fault_i[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else begin
        cur_q  <= cur_d;
        prev_q <= cur_q;
      end
    end

    assign stat_o[p*4 +: 4] = cur_q;
    assign hit[p] = int_en_i[p] && (cur_q != prev_q);
  end

  assign change_o = |hit;
endmodule

// File: rtl/csr_window_mux.sv
module csr_window_mux #(
  parameter int NUM_PORTS = 3
) (
  input  logic [2:0]             page_i,
  input  logic [3:0]             port_i,
  input  logic [2:0]             ofs_i,
  input  logic [NUM_PORTS*4-1:0] stat_i,
  input  logic [NUM_PORTS-1:0]   int_en_i,
  output logic                   port_ok_o,
  output logic [7:0]             data_o
);
  import phy_csr_pkg::*;

  localparam logic [4:0] NP = 5'(NUM_PORTS);

  logic [3:0] sel_stat;
  logic       sel_ie;

  assign port_ok_o = (page_i == PAGE_PORT) && ({1'b0, port_i} < NP);

  always_comb begin
    sel_stat = '0;
    sel_ie   = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (port_i == 4'(i)) begin
        sel_stat = stat_i[i*4 +: 4];
        sel_ie   = int_en_i[i];
      end
    end
  end

  always_comb begin
    data_o = '0;
    if (port_ok_o) begin
      case (ofs_i)
        OFS_PSTAT: data_o = {4'b0, sel_stat};
        OFS_INTEN: data_o = {7'b0, sel_ie};
        default:   data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_csr_file.sv
module phy_csr_file #(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [7:0]           rdata,
  input  logic                 loop_pulse,
  input  logic                 arb_timeout_pulse,
  input  logic                 cable_pwr_ok,
  input  logic [NUM_PORTS-1:0] port_connected,
  input  logic [NUM_PORTS-1:0] port_bias,
  input  logic [NUM_PORTS-1:0] port_disabled,
  input  logic [NUM_PORTS-1:0] port_fault,
  input  logic [NUM_PORTS-1:0] port_resume,
  output logic                 short_reset_req,
  output logic                 accel_en,
  output logic                 multi_en
);
  import phy_csr_pkg::*;

  logic                   wdog_q, wdog_d;
  logic                   accel_q, accel_d;
  logic                   multi_q, multi_d;
  logic                   srst_q, srst_d;
  logic [2:0]             page_q, page_d;
  logic [3:0]             port_q, port_d;
  logic [NUM_PORTS-1:0]   int_en_q, int_en_d;
  logic                   pwr_cur_q, pwr_prev_q;
  logic [7:0]             rdata_q, rdata_d;

  logic [N_STAT-1:0]      stat_q, stat_set, stat_clr;
  logic [NUM_PORTS*4-1:0] port_stat;
  logic                   port_change;
  logic                   port_ok;
  logic [7:0]             win_data;

  logic wr_ctrl, wr_stat, wr_sel, wr_inten, in_window;

  assign in_window = addr[3];
  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_stat   = wr_en && (addr == A_STATUS);
  assign wr_sel    = wr_en && (addr == A_SELECT);
  assign wr_inten  = wr_en && in_window && (addr[2:0] == OFS_INTEN) && port_ok;

  csr_port_monitor #(.NUM_PORTS(NUM_PORTS)) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .connected_i (port_connected),
    .bias_i      (port_bias),
    .disabled_i  (port_disabled),
    .fault_i     (port_fault),
    .int_en_i    (int_en_q),
    .stat_o      (port_stat),
    .change_o    (port_change)
  );

  csr_window_mux #(.NUM_PORTS(NUM_PORTS)) u_win (
    .page_i    (page_q),
    .port_i    (port_q),
    .ofs_i     (addr[2:0]),
    .stat_i    (port_stat),
    .int_en_i  (int_en_q),
    .port_ok_o (port_ok),
    .data_o    (win_data)
  );

  always_comb begin
    stat_set         = '0;
    stat_set[S_LOOP] = loop_pulse;
    stat_set[S_TMO]  = arb_timeout_pulse;
    stat_set[S_PWR]  = pwr_prev_q && !pwr_cur_q;
    stat_set[S_PEVT] = port_change || (wdog_q && (|port_resume));
    stat_clr         = wr_stat ? wdata[N_STAT-1:0] : '0;
  end

  for (genvar s = 0; s < N_STAT; s++) begin : g_stat
    csr_w1c_bit #(.RST_VAL(STAT_RST[s])) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stat_set[s]),
      .clr_i (stat_clr[s]),
      .q_o   (stat_q[s])
    );
  end

  always_comb begin
    wdog_d   = wdog_q;
    accel_d  = accel_q;
    multi_d  = multi_q;
    srst_d   = 1'b0;
    page_d   = page_q;
    port_d   = port_q;
    int_en_d = int_en_q;
    if (wr_ctrl) begin
      wdog_d  = wdata[C_WATCHDOG];
      accel_d = wdata[C_ACCEL];
      multi_d = wdata[C_MULTI];
      srst_d  = wdata[C_SRST];
    end
    if (wr_sel) begin
      page_d = wdata[2:0];
      port_d = wdata[7:4];
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (wr_inten && (port_q == 4'(i))) int_en_d[i] = wdata[0];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = '0;
      if (in_window) rdata_d = win_data;
      else begin
        case (addr)
          A_CTRL:   rdata_d = {5'b0, multi_q, accel_q, wdog_q};
          A_STATUS: rdata_d = {{(8-N_STAT){1'b0}}, stat_q};
          A_SELECT: rdata_d = {port_q, 1'b0, page_q};
          default:  rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdog_q     <= 1'b0;
      accel_q    <= 1'b0;
      multi_q    <= 1'b0;
      srst_q     <= 1'b0;
      page_q     <= '0;
      port_q     <= '0;
      int_en_q   <= '0;
      pwr_cur_q  <= 1'b0;
      pwr_prev_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      wdog_q     <= wdog_d;
      accel_q    <= accel_d;
      multi_q    <= multi_d;
      srst_q     <= srst_d;
      page_q     <= page_d;
      port_q     <= port_d;
      int_en_q   <= int_en_d;
      pwr_cur_q  <= cable_pwr_ok;
      pwr_prev_q <= pwr_cur_q;
      rdata_q    <= rdata_d;
    end
  end

  assign rdata           = rdata_q;
  assign short_reset_req = srst_q;
  assign accel_en        = accel_q;
  assign multi_en        = multi_q;
endmodule

// File: rtl/phy_csr_checker.sv
module phy_csr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       loop_pulse,
  input logic       arb_timeout_pulse,
  input logic       short_reset_req,
  input logic       accel_en,
  input logic       multi_en,
  input logic [3:0] stat_q
);
  // R2: request lasts one cycle only
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    short_reset_req |=> !short_reset_req);

  // R2: request only follows a write of bit 3 to the control address
  a_r2_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    short_reset_req |-> $past(wr_en && addr == 4'd0 && wdata[3]));

  // R2: request bit reads back as zero
  a_r2_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd0) |=> !rdata[3]);

  // R5 and R4: a loop pulse latches even during a clear
  a_r5_loop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    loop_pulse |=> stat_q[0]);

  a_r5_tmo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    arb_timeout_pulse |=> stat_q[1]);

  // R3: clear without a competing set
  a_r3_loop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1 && wdata[0] && !loop_pulse) |=> !stat_q[0]);

  // R9: control bits follow the written data
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd0) |=>
      (accel_en == $past(wdata[1]) && multi_en == $past(wdata[2])));

  // R12: read data holds without a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind phy_csr_file phy_csr_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .addr              (addr),
  .wdata             (wdata),
  .wr_en             (wr_en),
  .rd_en             (rd_en),
  .rdata             (rdata),
  .loop_pulse        (loop_pulse),
  .arb_timeout_pulse (arb_timeout_pulse),
  .short_reset_req   (short_reset_req),
  .accel_en          (accel_en),
  .multi_en          (multi_en),
  .stat_q            (stat_q)
);

// File: tb/tb_phy_csr_file.sv
module tb_phy_csr_file;
  localparam int NP = 3;

  logic          clk, rst_n;
  logic [3:0]    addr;
  logic [7:0]    wdata, rdata;
  logic          wr_en, rd_en;
  logic          loop_pulse, arb_timeout_pulse, cable_pwr_ok;
  logic [NP-1:0] port_connected, port_bias, port_disabled, port_fault, port_resume;
  logic          short_reset_req, accel_en, multi_en;

  int checks = 0;
  int failures = 0;

  phy_csr_file #(.NUM_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .loop_pulse(loop_pulse),
    .arb_timeout_pulse(arb_timeout_pulse), .cable_pwr_ok(cable_pwr_ok),
    .port_connected(port_connected), .port_bias(port_bias),
    .port_disabled(port_disabled), .port_fault(port_fault),
    .port_resume(port_resume), .short_reset_req(short_reset_req),
    .accel_en(accel_en), .multi_en(multi_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write?, write addr, write data, read addr, expected}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'd2, 8'h00, 4'd8,  8'h01},  // port 0 status
    {1'b1, 4'd2, 8'h10, 4'd8,  8'h06},  // port 1 status
    {1'b1, 4'd2, 8'h20, 4'd8,  8'h08},  // port 2 status
    {1'b1, 4'd9, 8'h01, 4'd9,  8'h01},  // port 2 interrupt enable
    {1'b1, 4'd2, 8'h30, 4'd8,  8'h00},  // port 3 absent
    {1'b1, 4'd9, 8'h01, 4'd9,  8'h00},  // write to absent port ignored
    {1'b1, 4'd2, 8'h00, 4'd9,  8'h00},  // port 0 enable untouched
    {1'b1, 4'd2, 8'h01, 4'd8,  8'h00},  // page 1 unimplemented
    {1'b1, 4'd9, 8'h01, 4'd9,  8'h00},  // write on page 1 ignored
    {1'b1, 4'd2, 8'h20, 4'd9,  8'h01},  // port 2 enable kept
    {1'b1, 4'd2, 8'h20, 4'd10, 8'h00}   // unused offset
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    loop_pulse = 1'b0; arb_timeout_pulse = 1'b0; cable_pwr_ok = 1'b0;
    port_connected = 3'b001; port_bias = 3'b010;
    port_disabled = 3'b010; port_fault = 3'b100; port_resume = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 outputs", {5'b0, short_reset_req, accel_en, multi_en}, 8'h00);
    bus_read(4'd0, rd); check("R1 control", rd, 8'h00);
    bus_read(4'd1, rd); check("R1 status", rd, 8'h04);
    bus_read(4'd2, rd); check("R1 select", rd, 8'h00);
    bus_read(4'd5, rd); check("R11 addr 5", rd, 8'h00);

    // R3 write zero keeps, write one clears
    bus_write(4'd1, 8'h00);
    bus_read(4'd1, rd); check("R3 zero keeps", rd, 8'h04);
    bus_write(4'd1, 8'h04);
    bus_read(4'd1, rd); check("R3 one clears", rd, 8'h00);

    // R10 / R11 window table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) bus_write(VEC[i][23:20], VEC[i][19:12]);
      bus_read(VEC[i][11:8], rd);
      check($sformatf("R10 R11 vector %0d", i), rd, VEC[i][7:0]);
    end

    // R6 power failure edge
    cable_pwr_ok = 1'b1; idle(4);
    bus_read(4'd1, rd); check("R6 no edge", rd, 8'h00);
    cable_pwr_ok = 1'b0; idle(4);
    bus_read(4'd1, rd); check("R6 falling edge", rd, 8'h04);
    bus_write(4'd1, 8'h04);

    // R5 event pulses
    @(negedge clk); loop_pulse = 1'b1;
    @(negedge clk); loop_pulse = 1'b0;
    bus_read(4'd1, rd); check("R5 loop", rd, 8'h01);
    @(negedge clk); arb_timeout_pulse = 1'b1;
    @(negedge clk); arb_timeout_pulse = 1'b0;
    bus_read(4'd1, rd); check("R5 timeout", rd, 8'h03);
    bus_write(4'd1, 8'h03);
    bus_read(4'd1, rd); check("R3 clear both", rd, 8'h00);

    // R4 set beats clear
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd1; wdata = 8'h01; loop_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; loop_pulse = 1'b0;
    bus_read(4'd1, rd); check("R4 set wins", rd, 8'h01);
    bus_write(4'd1, 8'h01);

    // R2 short reset request
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd0; wdata = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 pulse high", {7'b0, short_reset_req}, 8'h01);
    @(negedge clk);
    check("R2 pulse ends", {7'b0, short_reset_req}, 8'h00);
    bus_read(4'd0, rd); check("R2 reads zero", rd, 8'h00);

    // R9 control bits
    bus_write(4'd0, 8'h06);
    check("R9 outputs", {6'b0, multi_en, accel_en}, 8'h03);
    bus_read(4'd0, rd); check("R9 readback", rd, 8'h06);

    // R8 resume gated by watchdog
    bus_write(4'd0, 8'h00);
    @(negedge clk); port_resume = 3'b010;
    @(negedge clk); port_resume = '0;
    bus_read(4'd1, rd); check("R8 watchdog off", rd, 8'h00);
    bus_write(4'd0, 8'h01);
    @(negedge clk); port_resume = 3'b001;
    @(negedge clk); port_resume = '0;
    bus_read(4'd1, rd); check("R8 watchdog on", rd, 8'h08);
    bus_write(4'd0, 8'h00);
    bus_write(4'd1, 8'h08);

    // R7 port change gated by interrupt enable (only port 2 enabled)
    port_connected[1] = 1'b1; idle(4);
    bus_read(4'd1, rd); check("R7 disabled port", rd, 8'h00);
    port_fault[2] = 1'b0; idle(4);
    bus_read(4'd1, rd); check("R7 enabled port", rd, 8'h08);

    // R12 read data holds without strobe
    bus_read(4'd1, rd);
    @(negedge clk); addr = 4'd0; idle(3);
    check("R12 hold", rdata, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule